// File: doc/BRIEF.md
# Symmetric Linear-Phase FIR Filter with Table-Based Multiplication

This block is an eight-tap, fixed-coefficient, linear-phase FIR filter. It accepts one signed sample per clock and produces one full-precision signed result per accepted sample. It needs no hardware multipliers. Because the impulse response is mirror-symmetric, each pair of taps that share a coefficient is summed first. This gives four pre-add words. Each bit position across those four words forms a 4-bit address into a 16-entry table. Every table entry holds a precomputed sum of coefficients. A binary tree of shift-and-add stages then weights each table output by its bit significance and combines them into the result.

The four distinct coefficients are elaboration-time parameters, and the tables are computed from them during elaboration. The table that serves the sign bit of the pre-add words holds negated sums, which makes two's complement inputs come out correctly. A register follows every table and every adder level. This gives a fixed latency of five clocks and a throughput of one result per clock. A valid flag travels alongside the data. The result register keeps its value between valid pulses.

Top module: `fir_da_sym`

## Requirements
- R1: While `rst_n` is low and after it is released, `res_valid` is 0, `res_data` is 0, and the tap history is all zeros. Results computed before eight samples have been accepted therefore treat the missing older samples as zero.
- R2: A sample on `smp_data` is accepted at a rising edge only if `smp_valid` is high. When `smp_valid` is low, `smp_data` is ignored and the tap history does not move.
- R3: Each result equals h1·(x[n]+x[n-7]) + h2·(x[n-1]+x[n-6]) + h3·(x[n-2]+x[n-5]) + h4·(x[n-3]+x[n-4]), where x[n] is the newest accepted sample. The result is exact in two's complement over 19 bits, with no rounding and no saturation.
- R4: If a sample is accepted at edge E, its result and `res_valid` high appear together after the fifth rising edge, counting E as the first.
- R5: `res_valid` pulses for exactly one cycle per accepted sample, and results come out in acceptance order. With samples on every clock, a result comes out on every clock.
- R6: `res_data` keeps its value in every cycle where `res_valid` is low.
- R7: Inputs at the extremes of the 7-bit signed range (−64 and +63), including runs of −64, give the exact R3 value.
- R8: A single input of 1 among zeros gives the results h1, h2, h3, h4, h4, h3, h2, h1 on consecutive accepted samples, and then 0.
- R9: Table entry i holds the sum of those h(k) for which address bit k−1 is set. Bit 0 of the address comes from the pair (x[n], x[n-7]). The table for the top pre-add bit holds the negation of each sum. This is observable when a single −1 input drives every pre-add bit to 1: the results are −h1, −h2, −h3, −h4, −h4, −h3, −h2, −h1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Marks `smp_data` as a sample to accept this cycle |
| smp_data | input | 7 | Signed input sample |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 19 | Signed full-precision filter result |

## Verification
Some internal faults show up at the ports in distinctive ways. A wrong table entry, a missing negation on the sign-bit table, or a wrong shift at one tree level makes `res_data` differ from the direct-convolution reference. This shows up on the first result whose pre-add bits select that entry or that level, which is at most five clocks after the offending sample, and impulse, negative-impulse and extreme-value patterns reach those cases on purpose. A tap history that moves on an idle cycle corrupts every later result. A break in the valid delay chain moves or drops `res_valid` relative to the cycle predicted by the model, so the flag is compared on every clock as well as the data.

// File: rtl/fir_da_pkg.sv
`timescale 1ns/1ps
package fir_da_pkg;

  // Sign treatment of one bit-slice table
  typedef enum logic {
    SLICE_POS = 1'b0,
    SLICE_NEG = 1'b1
  } slice_sign_e;

  // Left shift applied to the upper operand at tree level lvl (0-based)
  function automatic int level_shift(input int lvl);
    return 1 << lvl;
  endfunction

endpackage

// File: rtl/fir_da_taps.sv
`timescale 1ns/1ps
module fir_da_taps #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 7,
  localparam int HALF  = TAPS / 2,
  localparam int PW    = DATA_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [DATA_W-1:0]             sample_i,
  output logic [HALF-1:0][PW-1:0]       pair_o
);

  logic [TAPS-1:0][DATA_W-1:0] line_q;
  logic [TAPS-1:0][DATA_W-1:0] line_d;

  // next state: shift by one position, newest sample at index 0
  always_comb begin
    line_d[0] = sample_i;
    for (int i = 1; i < TAPS; i++) begin
      line_d[i] = line_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (load_i) begin
      line_q <= line_d;
    end
  end

  // mirrored pre-adders, one bit wider than the samples
  for (genvar k = 0; k < HALF; k++) begin : g_pair
    assign pair_o[k] = {line_q[k][DATA_W-1], line_q[k]}
                     + {line_q[TAPS-1-k][DATA_W-1], line_q[TAPS-1-k]};
  end

  // R2
  taps_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (line_q[0] == $past(sample_i)));

  // R2
  taps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(line_q));

endmodule

// File: rtl/fir_da_slice.sv
`timescale 1ns/1ps
module fir_da_slice #(
  parameter int                      HALF   = 4,
  parameter int                      COEF_W = 8,
  parameter int                      ENT_W  = 11,
  parameter logic [HALF*COEF_W-1:0]  COEFS  = '0,
  parameter fir_da_pkg::slice_sign_e NEG    = fir_da_pkg::SLICE_POS,
  localparam int ENTRIES = 1 << HALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [HALF-1:0]   addr_i,
  output logic [ENT_W-1:0]  val_o
);

  typedef logic [ENTRIES-1:0][ENT_W-1:0] table_t;

  // coefficient-sum table computed at elaboration
  function automatic table_t build_table();
    table_t             t;
    logic signed [ENT_W-1:0] acc;
    for (int i = 0; i < ENTRIES; i++) begin
      acc = '0;
      for (int k = 0; k < HALF; k++) begin
        if (i[k]) begin
          acc = acc + ENT_W'($signed(COEFS[k*COEF_W +: COEF_W]));
        end
      end
      t[i] = (NEG == fir_da_pkg::SLICE_NEG) ? -acc : acc;
    end
    return t;
  endfunction

  localparam table_t TABLE = build_table();

  logic [ENT_W-1:0] val_d;

  always_comb begin
    val_d = TABLE[addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_o <= '0;
    end else if (en_i) begin
      val_o <= val_d;
    end
  end

  // R9
  lut_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (addr_i == '0)) |=> (val_o == '0));

  // R6
  lut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(val_o));

endmodule

// File: rtl/fir_da_tree.sv
`timescale 1ns/1ps
module fir_da_tree #(
  parameter int LEVELS = 3,
  parameter int OUT_W  = 19,
  localparam int NT    = 1 << LEVELS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LEVELS-1:0]           en_i,
  input  logic [NT-1:0][OUT_W-1:0]    leaf_i,
  output logic [OUT_W-1:0]            root_o
);

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int N  = NT >> (l + 1);
    localparam int SH = fir_da_pkg::level_shift(l);

    logic [2*N-1:0][OUT_W-1:0] src;
    logic [N-1:0][OUT_W-1:0]   sum_d;
    logic [N-1:0][OUT_W-1:0]   sum_q;

    if (l == 0) begin : g_from_leaf
      assign src = leaf_i;
    end else begin : g_from_node
      assign src = g_lvl[l-1].sum_q;
    end

    // wrap-around arithmetic: the result fits OUT_W, carries out are dropped
    always_comb begin
      for (int n = 0; n < N; n++) begin
        sum_d[n] = src[2*n] + (src[2*n+1] << SH);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
      end else if (en_i[l]) begin
        sum_q <= sum_d;
      end
    end

    // R6
    tree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i[l] |=> $stable(sum_q));
  end

  assign root_o = g_lvl[LEVELS-1].sum_q[0];

endmodule

// File: rtl/fir_da_sym.sv
`timescale 1ns/1ps
module fir_da_sym #(
  parameter int                   TAPS   = 8,
  parameter int                   DATA_W = 7,
  parameter int                   COEF_W = 8,
  parameter logic [(TAPS/2)*COEF_W-1:0] COEFS = 32'h7F80_2DF7
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              smp_valid,
  input  logic [DATA_W-1:0]                                 smp_data,
  output logic                                              res_valid,
  output logic signed [DATA_W+COEF_W+$clog2(TAPS/2)+1:0]    res_data
);

  localparam int HALF   = TAPS / 2;
  localparam int PW     = DATA_W + 1;
  localparam int LEVELS = $clog2(PW);
  localparam int NT     = 1 << LEVELS;
  localparam int ENT_W  = COEF_W + $clog2(HALF) + 1;
  localparam int OUT_W  = DATA_W + COEF_W + $clog2(HALF) + 2;
  localparam int LAT    = LEVELS + 2;
  localparam int CNT_W  = $clog2(LAT + 1);

  logic [HALF-1:0][PW-1:0]    pair;
  logic [NT-1:0][OUT_W-1:0]   leaf;
  logic [OUT_W-1:0]           root;
  logic [LAT:1]               vld_q;
  logic [LAT:1]               vld_d;

  // valid delay line matched to the data pipeline
  always_comb begin
    vld_d = {vld_q[LAT-1:1], smp_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  fir_da_taps #(
    .TAPS   (TAPS),
    .DATA_W (DATA_W)
  ) u_taps (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (smp_valid),
    .sample_i (smp_data),
    .pair_o   (pair)
  );

  for (genvar b = 0; b < NT; b++) begin : g_slice
    if (b < PW) begin : g_used
      logic [HALF-1:0]  addr;
      logic [ENT_W-1:0] val;

      for (genvar k = 0; k < HALF; k++) begin : g_addr
        assign addr[k] = pair[k][b];
      end

      fir_da_slice #(
        .HALF   (HALF),
        .COEF_W (COEF_W),
        .ENT_W  (ENT_W),
        .COEFS  (COEFS),
        .NEG    ((b == PW - 1) ? fir_da_pkg::SLICE_NEG : fir_da_pkg::SLICE_POS)
      ) u_slice (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (vld_q[1]),
        .addr_i (addr),
        .val_o  (val)
      );

      assign leaf[b] = OUT_W'($signed(val));
    end else begin : g_pad
      assign leaf[b] = '0;
    end
  end

  fir_da_tree #(
    .LEVELS (LEVELS),
    .OUT_W  (OUT_W)
  ) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (vld_q[LEVELS+1:2]),
    .leaf_i (leaf),
    .root_o (root)
  );

  assign res_valid = vld_q[LAT];
  assign res_data  = $signed(root);

  // cycles since reset release, saturating at the latency
  logic [CNT_W-1:0] since_q;
  logic [CNT_W-1:0] since_d;

  always_comb begin
    since_d = (since_q == CNT_W'(LAT)) ? since_q : since_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
    end else begin
      since_q <= since_d;
    end
  end

  // R4
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == CNT_W'(LAT)) |-> (res_valid == $past(smp_valid, LAT)));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));

endmodule

// File: tb/fir_da_sym_tb.sv
`timescale 1ns/1ps
module fir_da_sym_tb;

  localparam int H1 = -9;
  localparam int H2 = 45;
  localparam int H3 = -128;
  localparam int H4 = 127;
  localparam logic [31:0] TB_COEFS = {8'(H4), 8'(H3), 8'(H2), 8'(H1)};
  localparam int LAT = 5;
  localparam int OUT_W = 19;

  logic             clk;
  logic             rst_n;
  logic             smp_valid;
  logic [6:0]       smp_data;
  logic             res_valid;
  logic signed [OUT_W-1:0] res_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int hist [8];
  int hv [LAT+1];
  bit pv [LAT+1];
  int hold = 0;

  fir_da_sym #(
    .TAPS   (8),
    .DATA_W (7),
    .COEF_W (8),
    .COEFS  (TB_COEFS)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int ref_y();
    return H1 * (hist[0] + hist[7]) + H2 * (hist[1] + hist[6])
         + H3 * (hist[2] + hist[5]) + H4 * (hist[3] + hist[4]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, advance the model, sample after the edge
  task automatic step(input bit v, input int x, input string tag);
    int y;
    @(negedge clk);
    smp_valid = v;
    smp_data  = 7'(x);
    if (v) begin
      for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
    end
    y = ref_y();
    for (int i = LAT; i > 1; i--) begin
      pv[i] = pv[i-1];
      hv[i] = hv[i-1];
    end
    pv[1] = v;
    hv[1] = y;
    if (pv[LAT]) hold = hv[LAT];
    @(posedge clk);
    #1;
    check({tag, " R4 R5 valid"}, int'(res_valid), int'(pv[LAT]));
    check({tag, " R6 data"}, int'(res_data), hold);
  endtask

  function automatic int rnd_sample();
    return int'($urandom_range(127)) - 64;
  endfunction

  initial begin
    rst_n = 0;
    smp_valid = 0;
    smp_data = '0;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    for (int i = 0; i <= LAT; i++) begin
      pv[i] = 0;
      hv[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", int'(res_valid), 0);
    check("R1 reset data", int'(res_data), 0);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(0, 0, "R1");

    // impulse of +1 gives the coefficients in mirrored order
    step(1, 1, "R8");
    for (int i = 0; i < 14; i++) step(1, 0, "R8");
    // impulse of -1 drives every pre-add bit, sign slice included
    step(1, -1, "R9");
    for (int i = 0; i < 14; i++) step(1, 0, "R9");

    // idle cycles with junk on the data input are ignored
    for (int i = 0; i < 300; i++) begin
      bit v = ($urandom_range(1) == 1);
      step(v, rnd_sample(), "R2");
    end
    for (int i = 0; i < 6; i++) step(0, rnd_sample(), "R2");

    // back-to-back random samples
    for (int i = 0; i < 500; i++) step(1, rnd_sample(), "R3");

    // extremes of the signed input range
    for (int i = 0; i < 12; i++) step(1, -64, "R7");
    for (int i = 0; i < 12; i++) step(1, 63, "R7");
    for (int i = 0; i < 16; i++) step(1, (i % 2 == 0) ? -64 : 63, "R7");
    for (int i = 0; i < 16; i++) step(1, ((i / 4) % 2 == 0) ? -64 : 63, "R7");
    for (int i = 0; i < 8; i++) step(0, 0, "R6");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule